// File: doc/BRIEF.md
# Open-Row SDRAM Read Controller

This block turns read requests into command sequences for one bank of a synchronous DRAM. Each request carries a flat word address and a burst length. The block splits the address into a row part and a column part. It remembers which row it last opened and keeps that row open between requests. When a request targets the open row, the block goes straight to the column command. When the request targets another row, the block closes the open row, waits, opens the new row, waits again, and then issues the column command. The very first access after reset opens its row without a close step.

Three latencies are set at run time and counted in bus clocks. The first is the delay from the column command to the first data word. The second is the gap from row open to column command. The third is the gap from row close to the next row open. The block captures each data word from the bus in the cycle the timing predicts and forwards it with a valid strobe. A one-cycle done pulse marks the end of each burst. The request port uses a valid/ready handshake and accepts one request at a time.

Top module: `sdr_open_row_ctrl`

## Requirements
- R1: After reset, req_ready is 1, cmd_pre, cmd_act, cmd_col, rsp_valid and rsp_done are 0, and no row counts as open, so the first accepted request opens its row with no close command before it.
- R2: At most one of cmd_pre, cmd_act and cmd_col is high in any cycle. While cmd_act is high, cmd_addr carries the row field req_addr[COL_W+ROW_W-1:COL_W], zero-extended. While cmd_col is high, cmd_addr carries the column field req_addr[COL_W-1:0].
- R3: A request whose row equals the open row gives cmd_col in the first cycle after acceptance, with no cmd_pre and no cmd_act.
- R4: A request for a different row while a row is open gives cmd_pre in the first cycle after acceptance and cmd_act exactly RP cycles after cmd_pre.
- R5: cmd_col comes exactly RCD cycles after cmd_act. When no row is open, cmd_act comes in the first cycle after acceptance.
- R6: The block samples mem_rdata CL cycles after cmd_col and in each of the following cycles, req_len+1 words in all. Each word shows on rsp_data with rsp_valid high one cycle after it was on the bus.
- R7: rsp_done pulses for one cycle, one cycle after the last rsp_valid. req_ready is low from the cycle after acceptance until the cycle of rsp_done, and it is high in that cycle.
- R8: cfg_cl, cfg_rcd and cfg_rp are sampled only when a request is accepted, and a value of 0 counts as 1. Changing them during a request has no effect on that request's timing.
- R9: The setting CL=2, RCD=2, RP=3 gives, for a row change, cmd_pre at cycle 1, cmd_act at cycle 4, cmd_col at cycle 6, the first rsp_valid at cycle 9, and rsp_done at cycle 9+req_len+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_addr | input | ROW_W+COL_W | Start word address, row field above column field |
| req_len | input | LEN_W | Burst length minus one |
| cfg_cl | input | LAT_W | Column-to-data latency, 0 read as 1 |
| cfg_rcd | input | LAT_W | Row-open to column gap, 0 read as 1 |
| cfg_rp | input | LAT_W | Row-close to row-open gap, 0 read as 1 |
| cmd_pre | output | 1 | Close the open row |
| cmd_act | output | 1 | Row strobe: open the row on cmd_addr |
| cmd_col | output | 1 | Column strobe: read burst from column on cmd_addr |
| cmd_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_rdata | input | DATA_W | Read data bus from the memory |
| rsp_valid | output | 1 | rsp_data holds a burst word |
| rsp_data | output | DATA_W | Returned burst word |
| rsp_done | output | 1 | One-cycle pulse after the last word |

## Verification
Count cycles from the first cycle after the accepting edge. For a row change, cmd_pre is due at 1, cmd_act at 1+RP and cmd_col RCD cycles after that. For a first access, cmd_act is due at 1. For a row hit, cmd_col is due at 1. The k-th rsp_valid is due at col+CL+1+k, and rsp_done at col+CL+len+2. The bench samples every output at the falling edge of each cycle and logs the cycle number of each event. It compares these numbers with values its own functions derive from the sampled latencies. Its memory model drives the expected word only in the cycles where data is due and drives a marker value in every other cycle, so a capture that comes a cycle early or late shows up as a data mismatch.

// File: rtl/sdr_pkg.sv
// Package: shared types for the open-row SDRAM read controller.
// Assumes: single bank, reads only.
package sdr_pkg;

    // Sequencer states: close, open and column phases plus their wait phases
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_PRE   = 4'd1,
        ST_WRP   = 4'd2,
        ST_ACT   = 4'd3,
        ST_WRCD  = 4'd4,
        ST_COL   = 4'd5,
        ST_WCL   = 4'd6,
        ST_BURST = 4'd7,
        ST_FIN   = 4'd8
    } sdr_state_e;

endpackage

// File: rtl/sdr_row_tracker.sv
// Module: sdr_row_tracker
// Holds the address of the open row and a flag that says it is valid.
// Compares a lookup row against it. Assumes set_en is high only while the
// row strobe is issued. The flag is cleared on reset.
module sdr_row_tracker #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] look_row,
    output logic             open_vld,
    output logic             hit
);

    logic [ROW_W-1:0] open_row_q;

    // Record the row being opened; forget any open row on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld   <= 1'b0;
            open_row_q <= '0;
        end else if (set_en) begin
            open_vld   <= 1'b1;
            open_row_q <= set_row;
        end
    end

    // Same-row detection against the lookup address
    always_comb hit = open_vld && (look_row == open_row_q);

endmodule

// File: rtl/sdr_wait_timer.sv
// Module: sdr_wait_timer
// Down-counter for the latency waits. load presets the count. The count then
// falls by one per cycle and stops at zero. Assumes the caller loads N-2 so
// that a wait state entered after loading lasts N-1 cycles.
module sdr_wait_timer #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LAT_W-1:0] load_val,
    output logic             zero
);

    logic [LAT_W-1:0] cnt_q;

    // Preset on load, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - LAT_W'(1);
    end

    // Wait-over flag
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/sdr_burst_return.sv
// Module: sdr_burst_return
// While active, captures one word per cycle from the memory data bus, forwards
// it with a valid strobe one cycle later, and flags the cycle of the final word.
// Assumes active stays high for exactly len+1 cycles and then drops.
module sdr_burst_return #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              last,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    logic [LEN_W-1:0] idx_q;

    // Word index inside the burst, cleared between bursts
    always_ff @(posedge clk) begin
        if (!rst_n || !active) idx_q <= '0;
        else                   idx_q <= idx_q + LEN_W'(1);
    end

    // Register the bus word and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= active;
            if (active) rsp_data <= mem_rdata;
        end
    end

    // Final-word flag in the bus cycle of the last word
    always_comb last = active && (idx_q == len);

endmodule

// File: rtl/sdr_open_row_ctrl.sv
// Module: sdr_open_row_ctrl (top)
// Read controller for one SDRAM bank. Keeps the last row open and skips the
// close and open steps when the next request hits that row. Counts the
// programmable CL, RCD and RP latencies in bus clocks. Assumes the memory
// starts a burst CL cycles after the column command and auto-increments the
// column. Latencies are sampled when a request is accepted, and 0 counts as 1.
module sdr_open_row_ctrl
    import sdr_pkg::*;
#(
    parameter  int ROW_W  = 8,
    parameter  int COL_W  = 6,
    parameter  int DATA_W = 16,
    parameter  int LEN_W  = 3,
    parameter  int LAT_W  = 3,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int CA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [LAT_W-1:0]  cfg_cl,
    input  logic [LAT_W-1:0]  cfg_rcd,
    input  logic [LAT_W-1:0]  cfg_rp,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic              cmd_col,
    output logic [CA_W-1:0]   cmd_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_done
);

    localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);
    localparam logic [LAT_W-1:0] LAT_TWO = LAT_W'(2);

    sdr_state_e       state_q, state_d;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [LEN_W-1:0] len_q;
    logic [LAT_W-1:0] cl_q, rcd_q, rp_q;
    logic             accept, hit, open_vld;
    logic             tmr_load, tmr_zero, burst_last;
    logic [LAT_W-1:0] tmr_val;

    // Open-row bookkeeping against the incoming request row
    sdr_row_tracker #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (state_q == ST_ACT),
        .set_row  (row_q),
        .look_row (req_addr[ADDR_W-1:COL_W]),
        .open_vld (open_vld),
        .hit      (hit)
    );

    // Shared countdown for the RP, RCD and CL waits
    sdr_wait_timer #(.LAT_W(LAT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Burst word capture and forwarding
    sdr_burst_return #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ret (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_BURST),
        .len       (len_q),
        .mem_rdata (mem_rdata),
        .last      (burst_last),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always_comb accept = (state_q == ST_IDLE) && req_valid;

    // Latch the request and the clamped latencies at acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            len_q <= '0;
            cl_q  <= LAT_ONE;
            rcd_q <= LAT_ONE;
            rp_q  <= LAT_ONE;
        end else if (accept) begin
            row_q <= req_addr[ADDR_W-1:COL_W];
            col_q <= req_addr[COL_W-1:0];
            len_q <= req_len;
            cl_q  <= (cfg_cl  == '0) ? LAT_ONE : cfg_cl;
            rcd_q <= (cfg_rcd == '0) ? LAT_ONE : cfg_rcd;
            rp_q  <= (cfg_rp  == '0) ? LAT_ONE : cfg_rp;
        end
    end

    // Sequencer next-state and timer preset
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                if (hit)           state_d = ST_COL;
                else if (open_vld) state_d = ST_PRE;
                else               state_d = ST_ACT;
            end
            ST_PRE: begin
                if (rp_q == LAT_ONE) state_d = ST_ACT;
                else begin
                    state_d  = ST_WRP;
                    tmr_load = 1'b1;
                    tmr_val  = rp_q - LAT_TWO;
                end
            end
            ST_WRP:  if (tmr_zero) state_d = ST_ACT;
            ST_ACT: begin
                if (rcd_q == LAT_ONE) state_d = ST_COL;
                else begin
                    state_d  = ST_WRCD;
                    tmr_load = 1'b1;
                    tmr_val  = rcd_q - LAT_TWO;
                end
            end
            ST_WRCD: if (tmr_zero) state_d = ST_COL;
            ST_COL: begin
                if (cl_q == LAT_ONE) state_d = ST_BURST;
                else begin
                    state_d  = ST_WCL;
                    tmr_load = 1'b1;
                    tmr_val  = cl_q - LAT_TWO;
                end
            end
            ST_WCL:   if (tmr_zero) state_d = ST_BURST;
            ST_BURST: if (burst_last) state_d = ST_FIN;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and the end-of-burst pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rsp_done <= 1'b0;
        end else begin
            state_q  <= state_d;
            rsp_done <= (state_q == ST_FIN);
        end
    end

    // Command strobes and multiplexed address decoded from the state
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        cmd_pre   = (state_q == ST_PRE);
        cmd_act   = (state_q == ST_ACT);
        cmd_col   = (state_q == ST_COL);
        cmd_addr  = '0;
        if (cmd_act) cmd_addr = CA_W'(row_q);
        if (cmd_col) cmd_addr = CA_W'(col_q);
    end

endmodule

// Module: sdr_ctrl_checker
// Timing and protocol properties of the controller, seen at its ports.
// Keeps its own copy of the sampled RCD and RP values and its own gap counters.
module sdr_ctrl_checker #(
    parameter int LAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LAT_W-1:0] cfg_rcd,
    input logic [LAT_W-1:0] cfg_rp,
    input logic             cmd_pre,
    input logic             cmd_act,
    input logic             cmd_col,
    input logic             rsp_valid,
    input logic             rsp_done
);

    localparam int CW = LAT_W + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] rcd_s, rp_s, since_pre, since_act;
    logic          pend_pre, pend_act;

    // Own record of latencies and of the gaps since the last close and open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_s <= '0; rp_s <= '0;
            since_pre <= '0; since_act <= '0;
            pend_pre <= 1'b0; pend_act <= 1'b0;
        end else begin
            if (req_valid && req_ready) begin
                rcd_s <= (cfg_rcd == '0) ? CW'(1) : CW'(cfg_rcd);
                rp_s  <= (cfg_rp  == '0) ? CW'(1) : CW'(cfg_rp);
            end
            since_pre <= cmd_pre ? CW'(1) : ((since_pre == CMAX) ? CMAX : since_pre + CW'(1));
            since_act <= cmd_act ? CW'(1) : ((since_act == CMAX) ? CMAX : since_act + CW'(1));
            if (cmd_pre) pend_pre <= 1'b1; else if (cmd_act) pend_pre <= 1'b0;
            if (cmd_act) pend_act <= 1'b1; else if (cmd_col) pend_act <= 1'b0;
        end
    end

    a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre, cmd_act, cmd_col}));
    a_r4_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && pend_pre) |-> (since_pre == rp_s));
    a_r5_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_col && pend_act) |-> (since_act == rcd_s));
    a_r7_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($past(rsp_valid) && !rsp_valid));
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r7_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

endmodule

bind sdr_open_row_ctrl sdr_ctrl_checker #(.LAT_W(LAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cfg_rcd   (cfg_rcd),
    .cfg_rp    (cfg_rp),
    .cmd_pre   (cmd_pre),
    .cmd_act   (cmd_act),
    .cmd_col   (cmd_col),
    .rsp_valid (rsp_valid),
    .rsp_done  (rsp_done)
);

// File: tb/sdr_open_row_ctrl_tb.sv
// Bench for sdr_open_row_ctrl: directed corner cases plus seeded random
// requests, with expected cycle numbers and data from bench functions.
module sdr_open_row_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_addr = '0;
    logic [2:0]  req_len = '0;
    logic [2:0]  cfg_cl = 3'd2, cfg_rcd = 3'd2, cfg_rp = 3'd3;
    logic        cmd_pre, cmd_act, cmd_col;
    logic [7:0]  cmd_addr;
    logic [15:0] mem_rdata = 16'hDEAD;
    logic        rsp_valid, rsp_done;
    logic [15:0] rsp_data;

    int errs = 0;
    int checks = 0;
    bit bopen_vld = 0;
    int bopen_row = 0;

    always #10 clk = ~clk;

    sdr_open_row_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .cfg_cl(cfg_cl), .cfg_rcd(cfg_rcd),
        .cfg_rp(cfg_rp), .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_col(cmd_col),
        .cmd_addr(cmd_addr), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_done(rsp_done)
    );

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic logic [15:0] word_of(input int row, input int col);
        return 16'((row << 6) | (col & 63)) ^ 16'hA5C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One read request; all cycle numbers count from the first cycle after acceptance
    task automatic do_req(input int row, input int col, input int len,
                          input int cl, input int rcd, input int rp, input bit r9);
        int ecl, epre, eact, ecol, gpre, gact, gcol, gactaddr, gcoladdr;
        int fval, nwords, bad, gdone, rdy_bad;
        ecl = eff(cl);
        // Expected command cycles (R3, R4, R5)
        if (bopen_vld && row == bopen_row) begin
            epre = 0; eact = 0; ecol = 1;
        end else if (bopen_vld) begin
            epre = 1; eact = 1 + eff(rp); ecol = eact + eff(rcd);
        end else begin
            epre = 0; eact = 1; ecol = 1 + eff(rcd);
        end
        bopen_vld = 1; bopen_row = row;
        gpre = 0; gact = 0; gcol = 0; gactaddr = -1; gcoladdr = -1;
        fval = 0; nwords = 0; bad = 0; gdone = 0; rdy_bad = 0;
        chk(req_ready == 1'b1, "R7 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = 14'((row << 6) | col);
        req_len   = 3'(len);
        cfg_cl = 3'(cl); cfg_rcd = 3'(rcd); cfg_rp = 3'(rp);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int j = 1; j <= 80; j++) begin
            if (cmd_pre) gpre = j;
            if (cmd_act) begin gact = j; gactaddr = int'(cmd_addr); end
            if (cmd_col) begin gcol = j; gcoladdr = int'(cmd_addr); end
            if (rsp_valid) begin
                if (fval == 0) fval = j;
                if (j != ecol + ecl + 1 + nwords) bad++;
                if (rsp_data != word_of(row, col + nwords)) bad++;
                nwords++;
            end
            if (req_ready && !rsp_done) rdy_bad++;
            // R8: change latencies while busy; timing must not move
            if (j == 2) begin
                cfg_cl = 3'($urandom_range(0, 7));
                cfg_rcd = 3'($urandom_range(0, 7));
                cfg_rp = 3'($urandom_range(0, 7));
            end
            if (gcol > 0 && j >= gcol + ecl && j < gcol + ecl + len + 1)
                mem_rdata = word_of(row, col + (j - gcol - ecl));
            else
                mem_rdata = 16'hDEAD;
            if (rsp_done) begin gdone = j; break; end
            @(posedge clk); @(negedge clk);
        end
        mem_rdata = 16'hDEAD;
        chk(gpre == epre, "R4 precharge cycle", gpre, epre);
        chk(gact == eact, "R5 activate cycle", gact, eact);
        chk(gcol == ecol, "R3 column cycle", gcol, ecol);
        if (eact != 0) chk(gactaddr == row, "R2 row address", gactaddr, row);
        chk(gcoladdr == col, "R2 column address", gcoladdr, col);
        chk(fval == ecol + ecl + 1, "R6 first word cycle", fval, ecol + ecl + 1);
        chk(nwords == len + 1, "R6 word count", nwords, len + 1);
        chk(bad == 0, "R6 word timing and data", bad, 0);
        chk(gdone == ecol + ecl + len + 2, "R7 done cycle", gdone, ecol + ecl + len + 2);
        chk(rdy_bad == 0, "R7 ready low while busy", rdy_bad, 0);
        if (r9) chk(gdone == 10 + len && fval == 9, "R9 2-2-3 timeline", gdone, 10 + len);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5D2A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk({cmd_pre, cmd_act, cmd_col} == 3'b000, "R1 no command in reset", int'({cmd_pre, cmd_act, cmd_col}), 0);
        chk(rsp_valid == 1'b0 && rsp_done == 1'b0, "R1 no response in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !cmd_act, "R1 idle after reset release", int'(req_ready), 1);
        // R1/R5: first access opens a row without a close; then R3 hit, R4/R9 row change
        do_req(5, 10, 3, 2, 2, 3, 0);
        do_req(5, 20, 0, 2, 2, 3, 0);
        do_req(9, 4, 2, 2, 2, 3, 1);
        // R8: zero latencies read as 1
        do_req(3, 0, 1, 0, 0, 0, 0);
        do_req(3, 63, 0, 0, 0, 0, 0);
        // Largest latencies and burst, column wrap
        do_req(200, 62, 7, 7, 7, 7, 0);
        do_req(201, 60, 7, 1, 1, 1, 0);
        // Seeded random mix with few rows so hits and misses both occur
        for (int n = 0; n < 60; n++) begin
            int rsel;
            rsel = $urandom_range(0, 2);
            do_req((rsel == 0) ? 3 : (rsel == 1) ? 5 : 130,
                   $urandom_range(0, 63), $urandom_range(0, 7),
                   $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), 0);
            if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule